// File: doc/BRIEF.md
# Rotating-Priority Interrupt Resolver

This block is the core of an eight-level interrupt controller of the classic personal-computer kind. It keeps three 8-bit state vectors: pending requests, levels in service and masked levels. It also keeps a rotating lowest-priority pointer and two mode flags. Each cycle it picks the most urgent unmasked pending request. It raises its interrupt line when that request may preempt the work already in service, and it shows the winning level on a 3-bit vector output.

Software controls the block through a byte-wide command port with one address bit. The commands are an initialization word, a mask load, several end-of-interrupt and priority-rotation forms, and a mode word. The mode word turns special mask mode on or off. While special mask mode is on, levels in service no longer hold back other levels. Only the mask decides who may interrupt. In the same mode, a non-specific end-of-interrupt passes over in-service levels that are masked.

Top module: `irq_prio_resolver`

## Requirements
- R1: After reset, no request, in-service or mask bit is set, the lowest-priority pointer is 7, both mode flags are off and `int_out` is low.
- R2: A command with `cmd_a0`=0 and `cmd_data[4]`=1 is the initialization word. It clears the in-service and mask registers, sets the pointer to 7 (level 0 most urgent), turns special mask mode off, and loads the nested-exception flag from `cmd_data[0]`. Pending requests are kept.
- R3: A command with `cmd_a0`=1 loads the mask from `cmd_data`. A masked pending level never drives `int_out`, and it is raised once its mask bit is cleared.
- R4: Urgency starts at the level one above the pointer and wraps through all eight levels. The command with `cmd_a0`=0 and `cmd_data[4:3]`=00 and `cmd_data[7:5]`=110 loads the pointer from `cmd_data[2:0]`.
- R5: With special mask mode off, `int_out` rises only when the most urgent unmasked request is strictly more urgent than the most urgent level in service. When the nested-exception flag is set, level 2 in service blocks nothing.
- R6: A request bit is set in any cycle its `req_in` bit is high. When `inta` is high while `int_out` is high, the request bit of `vec_out` is cleared and its in-service bit is set.
- R7: A command with `cmd_a0`=0 and `cmd_data[4:3]`=01 is the mode word. With `cmd_data[6]`=1 it loads special mask mode from `cmd_data[5]`. With `cmd_data[6]`=0 the mode is unchanged.
- R8: With special mask mode on, any unmasked pending level raises `int_out`, whatever is in service.
- R9: The command with `cmd_data[7:5]`=001 (and `cmd_a0`=0, `cmd_data[4:3]`=00) is a non-specific end-of-interrupt. It clears the most urgent in-service bit. In special mask mode it skips masked in-service bits. If no bit qualifies, nothing changes.
- R10: Code 011 clears the in-service bit named by `cmd_data[2:0]`. Codes 101 (non-specific) and 111 (specific) also clear a bit, and they then set the pointer to the level that was cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_in | input | 8 | Request inputs, one per level, sampled each cycle |
| cmd_valid | input | 1 | Command byte strobe |
| cmd_a0 | input | 1 | Command address bit: 1 selects mask load |
| cmd_data | input | 8 | Command byte |
| inta | input | 1 | Interrupt acknowledge |
| int_out | output | 1 | Interrupt request to the processor |
| vec_out | output | 3 | Level of the winning request, valid while int_out is high |

## Verification
All state is hidden, so a wrong register shows only through `int_out` and `vec_out`. A wrong in-service bit, pointer or mode flag is exposed by the next request: a level that should preempt stays silent, or a level that should wait is raised. The bench sets up such a request in the cycle right after the command that changed the state. An end-of-interrupt that clears the wrong level is then seen within one or two cycles, because a request placed between the two candidate levels reveals which of them is still in service.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

    // command byte field positions
    localparam int CMD_W       = 8;
    localparam int F_INIT      = 4;
    localparam int F_MODE      = 3;
    localparam int F_SMM_EN    = 6;
    localparam int F_SMM_VAL   = 5;
    localparam int F_NEST      = 0;

    // end-of-interrupt / priority operation codes (cmd_data[7:5])
    localparam logic [2:0] OP_EOI_NS = 3'b001;
    localparam logic [2:0] OP_EOI_SP = 3'b011;
    localparam logic [2:0] OP_ROT_NS = 3'b101;
    localparam logic [2:0] OP_ROT_SP = 3'b111;
    localparam logic [2:0] OP_SETPRI = 3'b110;

    typedef enum logic [3:0] {
        CMD_NONE,
        CMD_INIT,
        CMD_MASK,
        CMD_EOI_NS,
        CMD_EOI_SP,
        CMD_ROT_NS,
        CMD_ROT_SP,
        CMD_SETPRI,
        CMD_MODE
    } cmd_kind_e;

    typedef struct packed {
        cmd_kind_e         kind;
        logic [CMD_W-1:0]  mask;
        logic [2:0]        lvl;
        logic              smm_en;
        logic              smm_val;
        logic              nest;
    } cmd_t;

endpackage

// File: rtl/irq_cmd_decode.sv
module irq_cmd_decode
    import irq_prio_pkg::*;
(
    input  logic             valid_i,
    input  logic             a0_i,
    input  logic [CMD_W-1:0] data_i,
    output cmd_t             cmd_o
);

    always_comb begin
        cmd_o         = '0;
        cmd_o.kind    = CMD_NONE;
        cmd_o.mask    = data_i;
        cmd_o.lvl     = data_i[2:0];
        cmd_o.smm_en  = data_i[F_SMM_EN];
        cmd_o.smm_val = data_i[F_SMM_VAL];
        cmd_o.nest    = data_i[F_NEST];
        if (valid_i) begin
            if (a0_i) begin
                cmd_o.kind = CMD_MASK;
            end else if (data_i[F_INIT]) begin
                cmd_o.kind = CMD_INIT;
            end else if (data_i[F_MODE]) begin
                cmd_o.kind = CMD_MODE;
            end else begin
                case (data_i[7:5])
                    OP_EOI_NS: cmd_o.kind = CMD_EOI_NS;
                    OP_EOI_SP: cmd_o.kind = CMD_EOI_SP;
                    OP_ROT_NS: cmd_o.kind = CMD_ROT_NS;
                    OP_ROT_SP: cmd_o.kind = CMD_ROT_SP;
                    OP_SETPRI: cmd_o.kind = CMD_SETPRI;
                    default:   cmd_o.kind = CMD_NONE;
                endcase
            end
        end
    end

endmodule

// File: rtl/irq_prio_pick.sv
// Rotating priority picker: scans from base+1 upward with wrap and
// returns the first set level plus its rank (0 = most urgent).
module irq_prio_pick #(
    parameter int N = 8,
    parameter int W = $clog2(N)
) (
    input  logic [N-1:0] vec_i,
    input  logic [W-1:0] base_i,
    output logic         found_o,
    output logic [W-1:0] lvl_o,
    output logic [W-1:0] rank_o
);

    logic [W-1:0] cand;

    always_comb begin
        found_o = 1'b0;
        lvl_o   = '0;
        rank_o  = '0;
        cand    = '0;
        for (int k = 0; k < N; k++) begin
            cand = base_i + W'(k + 1);
            if (!found_o && vec_i[cand]) begin
                found_o = 1'b1;
                lvl_o   = cand;
                rank_o  = W'(k);
            end
        end
    end

    always_comb begin
        if (found_o) begin
            AST_PICK_HIT: assert (vec_i[lvl_o]) else $error("picker chose an empty level"); // R4
        end
    end

endmodule

// File: rtl/irq_prio_resolver.sv
module irq_prio_resolver
    import irq_prio_pkg::*;
#(
    parameter int N = 8,
    parameter int W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     req_in,
    input  logic             cmd_valid,
    input  logic             cmd_a0,
    input  logic [CMD_W-1:0] cmd_data,
    input  logic             inta,
    output logic             int_out,
    output logic [W-1:0]     vec_out
);

    localparam logic [W-1:0] PTR_RST  = W'(N - 1);
    localparam int           NEST_LVL = 2;
    localparam logic [N-1:0] ONE      = {{(N-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [N-1:0] irr;
        logic [N-1:0] isr;
        logic [N-1:0] imr;
        logic [W-1:0] lowprio;
        logic         smm;
        logic         nest;
    } state_t;

    localparam state_t ST_RST = '{
        irr: '0, isr: '0, imr: '0, lowprio: PTR_RST, smm: 1'b0, nest: 1'b0
    };

    state_t st_q, st_d;
    cmd_t   cmd;

    irq_cmd_decode u_dec (
        .valid_i (cmd_valid),
        .a0_i    (cmd_a0),
        .data_i  (cmd_data),
        .cmd_o   (cmd)
    );

    // ---------------- resolution vectors ----------------
    logic [N-1:0] cand_vec, blk_vec, eoi_vec;

    always_comb begin
        cand_vec = st_q.irr & ~st_q.imr;
        blk_vec  = st_q.isr;
        if (st_q.nest) begin
            blk_vec[NEST_LVL] = 1'b0;
        end
        if (st_q.smm) begin
            blk_vec = '0;
        end
        eoi_vec = st_q.smm ? (st_q.isr & ~st_q.imr) : st_q.isr;
    end

    logic         req_found, blk_found, eoi_found;
    logic [W-1:0] req_lvl, blk_lvl, eoi_lvl;
    logic [W-1:0] req_rank, blk_rank, eoi_rank;

    irq_prio_pick #(.N(N), .W(W)) u_pick_req (
        .vec_i   (cand_vec),
        .base_i  (st_q.lowprio),
        .found_o (req_found),
        .lvl_o   (req_lvl),
        .rank_o  (req_rank)
    );

    irq_prio_pick #(.N(N), .W(W)) u_pick_blk (
        .vec_i   (blk_vec),
        .base_i  (st_q.lowprio),
        .found_o (blk_found),
        .lvl_o   (blk_lvl),
        .rank_o  (blk_rank)
    );

    irq_prio_pick #(.N(N), .W(W)) u_pick_eoi (
        .vec_i   (eoi_vec),
        .base_i  (st_q.lowprio),
        .found_o (eoi_found),
        .lvl_o   (eoi_lvl),
        .rank_o  (eoi_rank)
    );

    assign int_out = req_found && (!blk_found || (req_rank < blk_rank));
    assign vec_out = req_lvl;

    logic         ack_hit;
    logic [N-1:0] ack_oh;

    assign ack_hit = inta && int_out;
    assign ack_oh  = ONE << req_lvl;

    // ---------------- next state ----------------
    always_comb begin
        st_d = st_q;
        if (ack_hit) begin
            st_d.irr = st_q.irr & ~ack_oh;
            st_d.isr = st_q.isr | ack_oh;
        end
        st_d.irr = st_d.irr | req_in;

        case (cmd.kind)
            CMD_INIT: begin
                st_d.isr     = '0;
                st_d.imr     = '0;
                st_d.lowprio = PTR_RST;
                st_d.smm     = 1'b0;
                st_d.nest    = cmd.nest;
            end
            CMD_MASK: begin
                st_d.imr = cmd.mask[N-1:0];
            end
            CMD_EOI_NS: begin
                if (eoi_found) begin
                    st_d.isr[eoi_lvl] = 1'b0;
                end
            end
            CMD_ROT_NS: begin
                if (eoi_found) begin
                    st_d.isr[eoi_lvl] = 1'b0;
                    st_d.lowprio      = eoi_lvl;
                end
            end
            CMD_EOI_SP: begin
                st_d.isr[cmd.lvl[W-1:0]] = 1'b0;
            end
            CMD_ROT_SP: begin
                st_d.isr[cmd.lvl[W-1:0]] = 1'b0;
                st_d.lowprio             = cmd.lvl[W-1:0];
            end
            CMD_SETPRI: begin
                st_d.lowprio = cmd.lvl[W-1:0];
            end
            CMD_MODE: begin
                if (cmd.smm_en) begin
                    st_d.smm = cmd.smm_val;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_RST;
        end else begin
            st_q <= st_d;
        end
    end

    // ---------------- assertions ----------------
    AST_ACK_TO_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_hit && cmd.kind == CMD_NONE) |=> st_q.isr[$past(vec_out)]) else $error("ack lost"); // R6

    AST_INIT_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd.kind == CMD_INIT) |=> (st_q.lowprio == PTR_RST && !st_q.smm && st_q.isr == '0 && st_q.imr == '0)) else $error("init"); // R2

    AST_MASKED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        int_out |-> !st_q.imr[vec_out]) else $error("masked level raised"); // R3

    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd.kind == CMD_MODE && !cmd.smm_en) |=> (st_q.smm == $past(st_q.smm))) else $error("mode changed"); // R7

    AST_SMM_EOI_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd.kind == CMD_EOI_NS && st_q.smm) |=> (($past(st_q.isr & st_q.imr) & ~st_q.isr) == '0)) else $error("masked isr cleared"); // R9

    AST_EOI_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd.kind == CMD_EOI_NS) |=> ($countones($past(st_q.isr) & ~st_q.isr) <= 1)) else $error("eoi cleared many"); // R9

    AST_EOI_MATCH_BLK: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.smm && !st_q.nest && blk_found) |-> (eoi_found && eoi_rank == blk_rank && eoi_lvl == blk_lvl)) else $error("pickers disagree"); // R9

endmodule

// File: tb/irq_prio_resolver_tb_top.sv
module irq_prio_resolver_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] req_in = '0;
    logic       cmd_valid = 1'b0;
    logic       cmd_a0 = 1'b0;
    logic [7:0] cmd_data = '0;
    logic       inta = 1'b0;
    logic       int_out;
    logic [2:0] vec_out;

    always #5 clk = ~clk;

    irq_prio_resolver dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_in    (req_in),
        .cmd_valid (cmd_valid),
        .cmd_a0    (cmd_a0),
        .cmd_data  (cmd_data),
        .inta      (inta),
        .int_out   (int_out),
        .vec_out   (vec_out)
    );

    typedef struct {
        bit       ei;
        bit [2:0] ev;
        string    tag;
    } exp_t;

    exp_t sb[$];
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;

    // monitor: compares one expected item per falling edge
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (int_out !== e.ei || (e.ei && vec_out !== e.ev)) begin
                errors++;
                $display("FAIL %s: int_out=%0b vec_out=%0d expected int_out=%0b vec_out=%0d",
                         e.tag, int_out, vec_out, e.ei, e.ev);
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
        req_in    = '0;
        cmd_valid = 1'b0;
        cmd_a0    = 1'b0;
        cmd_data  = '0;
        inta      = 1'b0;
    endtask

    task automatic expect_o(bit ei, bit [2:0] ev, string tag);
        exp_t e;
        e.ei = ei; e.ev = ev; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic pulse(bit [7:0] m);
        req_in = m;
        tick();
    endtask

    task automatic cmd(bit a0, bit [7:0] d);
        cmd_valid = 1'b1;
        cmd_a0    = a0;
        cmd_data  = d;
        tick();
    endtask

    task automatic ack();
        inta = 1'b1;
        tick();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        tick();
        expect_o(0, 0, "R1 reset idle");

        // nesting and non-specific EOI
        pulse(8'h08);  expect_o(1, 3, "R6 request 3 raised");
        ack();         expect_o(0, 0, "R6 ack moves 3 to service");
        pulse(8'h20);  expect_o(0, 0, "R5 level 5 blocked by 3");
        pulse(8'h02);  expect_o(1, 1, "R5 level 1 preempts 3");
        ack();         expect_o(0, 0, "R6 ack of 1");
        cmd(0, 8'h20); expect_o(0, 0, "R9 eoi clears 1, 3 still blocks");
        cmd(0, 8'h20); expect_o(1, 5, "R9 eoi clears 3, 5 raised");
        ack();
        cmd(0, 8'h20); expect_o(0, 0, "R9 all clear");

        // mask
        cmd(1, 8'h10);
        pulse(8'h10);  expect_o(0, 0, "R3 masked level 4 silent");
        cmd(1, 8'h00); expect_o(1, 4, "R3 unmask raises 4");
        ack();
        cmd(0, 8'h20);

        // set priority
        cmd(0, 8'hC2);
        pulse(8'h42);  expect_o(1, 6, "R4 pointer 2 favours 6 over 1");
        ack();         expect_o(0, 0, "R4 level 1 below 6");
        cmd(0, 8'h20); expect_o(1, 1, "R4 level 1 after eoi");
        ack();
        cmd(0, 8'h20); expect_o(0, 0, "R4 clear");

        // initialization word
        cmd(1, 8'hFF);
        cmd(0, 8'h10);
        pulse(8'h42);  expect_o(1, 1, "R2 pointer reset, mask cleared");
        ack();         expect_o(0, 0, "R2 6 blocked by 1");
        cmd(0, 8'h10); expect_o(1, 6, "R2 init clears service");
        ack();
        cmd(0, 8'h10); expect_o(0, 0, "R2 clear");

        // special mask mode
        cmd(0, 8'h68);
        pulse(8'h08);
        ack();
        pulse(8'h20);  expect_o(1, 5, "R8 service ignored in special mask");
        ack();
        cmd(1, 8'h08);
        cmd(0, 8'h20);
        cmd(0, 8'h48);
        pulse(8'h10);  expect_o(0, 0, "R9 masked 3 kept, 5 cleared");
        cmd(0, 8'h20); expect_o(1, 4, "R9 normal eoi clears masked 3");
        ack();
        cmd(0, 8'h20);
        cmd(1, 8'h00);

        // mode word without enable bit
        cmd(0, 8'h28);
        pulse(8'h08);
        ack();
        pulse(8'h20);  expect_o(0, 0, "R7 mode unchanged without enable");
        cmd(0, 8'h20); expect_o(1, 5, "R7 5 after eoi");
        ack();
        cmd(0, 8'h20);

        // eoi with every service bit masked
        cmd(0, 8'h68);
        pulse(8'h04);
        ack();
        cmd(1, 8'h04);
        cmd(0, 8'h20);
        cmd(0, 8'h48);
        cmd(1, 8'h00);
        pulse(8'h40);  expect_o(0, 0, "R9 no-op eoi kept 2");
        cmd(0, 8'h20); expect_o(1, 6, "R9 6 after 2 cleared");
        ack();
        cmd(0, 8'h20);

        // specific eoi
        pulse(8'h10);
        ack();
        pulse(8'h04);  expect_o(1, 2, "R5 2 preempts 4");
        ack();
        cmd(0, 8'h64); expect_o(0, 0, "R10 specific eoi of 4");
        pulse(8'h08);  expect_o(0, 0, "R10 level 2 still in service");
        cmd(0, 8'h62); expect_o(1, 3, "R10 specific eoi of 2");
        ack();
        cmd(0, 8'h20); expect_o(0, 0, "R10 clear");

        // rotate on specific eoi
        pulse(8'h20);
        ack();
        cmd(0, 8'hE5);
        pulse(8'h81);  expect_o(1, 7, "R10 rotate specific: 7 before 0");
        ack();
        cmd(0, 8'h20); expect_o(1, 0, "R10 then 0");
        ack();
        cmd(0, 8'h20);
        cmd(0, 8'hC7);

        // rotate on non-specific eoi
        pulse(8'h02);
        ack();
        cmd(0, 8'hA0);
        pulse(8'h09);  expect_o(1, 3, "R10 rotate non-specific: 3 before 0");
        ack();
        cmd(0, 8'h20); expect_o(1, 0, "R10 then 0");
        ack();
        cmd(0, 8'h20);
        cmd(0, 8'hC7);

        // nested-exception flag
        cmd(0, 8'h11);
        pulse(8'h04);
        ack();
        pulse(8'h08);  expect_o(1, 3, "R5 level 2 does not block with flag");
        ack();
        cmd(0, 8'h20);
        cmd(0, 8'h20);
        cmd(0, 8'h10); expect_o(0, 0, "R2 final init");

        while (sb.size() > 0) @(posedge clk);
        repeat (2) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule